// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers thirteen event sources into a single 32-bit event register and turns them into thirteen interrupt lines, one for each event. Hardware sources raise events with single-cycle pulses. Software reads the event register and a 32-bit enable mask over a simple register bus. It clears events by writing ones to them and sets which events reach their lines by overwriting the mask.

Each event sits at a fixed bit position, and the lines follow an order that is not sequential. An interrupt line is high when its event bit and its mask bit are both set. The lines are registered. They take their new value on the clock edge that also updates the event or mask register, so they always reflect the committed register state. Two register writes raise events as a side effect: any write to the management-frame offset, and a write to the transmit-control offset with bit 0 set.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset, the event register, the mask register and all thirteen `irq_o` lines read 0.
- R2: A pulse on `evt_set_i[l]` sets the event bit mapped to line l. That bit reads back as 1 at offset 0x004 from the next cycle.
- R3: A write to offset 0x004 clears every implemented event bit whose `reg_wdata_i` bit is 1 and leaves the others unchanged.
- R4: A write to offset 0x008 replaces all 32 mask bits. The new value reads back at 0x008 from the next cycle.
- R5: After any clock edge, `irq_o[l]` equals the AND of the event bit and the mask bit mapped to line l.
- R6: Line l maps to event bit b as follows: 0→27, 1→26, 2→19, 3→20, 4→25, 5→24, 6→23, 7→21, 8→31, 9→28, 10→22, 11→29, 12→30.
- R7: Any write to offset 0x040 sets event bit 23, the management-done event on line 6.
- R8: A write to offset 0x0C4 with data bit 0 set sets event bit 28, the stop-complete event on line 9. With data bit 0 clear, the write has no effect.
- R9: When a set pulse and a software clear hit the same bit in one cycle, the bit ends up set.
- R10: Event bits not listed in R6 always read 0, even after a pulse or write. Reads of offsets other than 0x004 and 0x008 return 0, and writes to other offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 10 | Byte offset for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| evt_set_i | input | 13 | Per-line event set pulses, indexed by line number |
| irq_o | output | 13 | Interrupt lines |

## Verification
The hardest case is a set pulse that lands in the same cycle as a software clear of the same bit. The correct result there is a single set bit, which the bench only sees if both strobes are aligned exactly. Directed steps create this collision on purpose. The random phase drives sparse set pulses together with write-one-to-clear data, so collisions also happen while the mask holds varied values. The transmit-control side effect depends on a single data bit, so it is reached with bit 0 both set and clear.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned NUM_LINES = 13;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 10;

  // event bit position driving each interrupt line
  function automatic int unsigned line_bit(int unsigned l);
    case (l)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      12:      return 30;
      default: return 0;
    endcase
  endfunction

  // reverse lookup, NUM_LINES when no line owns the bit
  function automatic int unsigned bit_line(int unsigned b);
    for (int unsigned l = 0; l < NUM_LINES; l++) begin
      if (line_bit(l) == b) return l;
    end
    return NUM_LINES;
  endfunction

endpackage

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned    AW          = evt_irq_pkg::AW,
  parameter int unsigned    DW          = evt_irq_pkg::DW,
  parameter int unsigned    NL          = evt_irq_pkg::NUM_LINES,
  parameter logic [AW-1:0]  EVT_OFS     = 'h004,
  parameter logic [AW-1:0]  MASK_OFS    = 'h008,
  parameter logic [AW-1:0]  MGMT_OFS    = 'h040,
  parameter logic [AW-1:0]  TXC_OFS     = 'h0C4,
  parameter int unsigned    MGMT_LINE   = 6,
  parameter int unsigned    GRA_LINE    = 9,
  parameter int unsigned    GRA_CTL_BIT = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_q_o,
  output logic [NL-1:0] mask_line_d_o,
  output logic [NL-1:0] clr_line_o,
  output logic [NL-1:0] side_line_o
);

  logic          evt_hit, mask_hit, mgmt_hit, txc_hit;
  logic [DW-1:0] mask_q, mask_d;

  assign evt_hit  = we_i && (addr_i == EVT_OFS);
  assign mask_hit = we_i && (addr_i == MASK_OFS);
  assign mgmt_hit = we_i && (addr_i == MGMT_OFS);
  assign txc_hit  = we_i && (addr_i == TXC_OFS);

  assign mask_d = mask_hit ? wdata_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  always_comb begin
    clr_line_o    = '0;
    side_line_o   = '0;
    mask_line_d_o = '0;
    for (int unsigned l = 0; l < NL; l++) begin
      mask_line_d_o[l] = mask_d[line_bit(l)];
      clr_line_o[l]    = evt_hit && wdata_i[line_bit(l)];
    end
    if (mgmt_hit)                        side_line_o[MGMT_LINE] = 1'b1;
    if (txc_hit && wdata_i[GRA_CTL_BIT]) side_line_o[GRA_LINE]  = 1'b1;
  end

  assign mask_q_o = mask_q;

endmodule

// File: rtl/evt_irq_latch.sv
module evt_irq_latch #(
  parameter int unsigned NL = evt_irq_pkg::NUM_LINES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] set_i,
  input  logic [NL-1:0] clr_i,
  output logic [NL-1:0] evt_d_o,
  output logic [NL-1:0] evt_q_o
);

  logic [NL-1:0] evt_q;

  // set after clear: a same-cycle pulse is never lost
  assign evt_d_o = (evt_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_d_o;
  end

  assign evt_q_o = evt_q;

endmodule

// File: rtl/evt_irq_line.sv
module evt_irq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic act_i,
  output logic irq_o
);

  logic irq_q;

  // touch the line only when its masked value moves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    irq_q <= 1'b0;
    else if (upd_i && act_i != irq_q) irq_q <= act_i;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int unsigned   AW       = evt_irq_pkg::AW,
  parameter int unsigned   DW       = evt_irq_pkg::DW,
  parameter int unsigned   NL       = evt_irq_pkg::NUM_LINES,
  parameter logic [AW-1:0] EVT_OFS  = 'h004,
  parameter logic [AW-1:0] MASK_OFS = 'h008,
  parameter logic [AW-1:0] MGMT_OFS = 'h040,
  parameter logic [AW-1:0] TXC_OFS  = 'h0C4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [NL-1:0] evt_set_i,
  output logic [NL-1:0] irq_o
);

  logic [DW-1:0] mask_q;
  logic [NL-1:0] mask_line_d, clr_line, side_line, set_line;
  logic [NL-1:0] evt_d, evt_q, act_d;
  logic [DW-1:0] evt_wide;
  logic          upd;

  evt_irq_regs #(
    .AW(AW), .DW(DW), .NL(NL),
    .EVT_OFS(EVT_OFS), .MASK_OFS(MASK_OFS), .MGMT_OFS(MGMT_OFS), .TXC_OFS(TXC_OFS)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .mask_q_o      (mask_q),
    .mask_line_d_o (mask_line_d),
    .clr_line_o    (clr_line),
    .side_line_o   (side_line)
  );

  assign set_line = evt_set_i | side_line;

  evt_irq_latch #(.NL(NL)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_line),
    .clr_i   (clr_line),
    .evt_d_o (evt_d),
    .evt_q_o (evt_q)
  );

  assign act_d = evt_d & mask_line_d;
  assign upd   = reg_we_i | (|evt_set_i);

  for (genvar l = 0; l < NL; l++) begin : g_line
    evt_irq_line u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd),
      .act_i  (act_d[l]),
      .irq_o  (irq_o[l])
    );
  end

  always_comb begin
    evt_wide = '0;
    for (int unsigned l = 0; l < NL; l++) evt_wide[line_bit(l)] = evt_q[l];
  end

  always_comb begin
    if (reg_addr_i == EVT_OFS)       reg_rdata_o = evt_wide;
    else if (reg_addr_i == MASK_OFS) reg_rdata_o = mask_q;
    else                             reg_rdata_o = '0;
  end

endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned   AW       = evt_irq_pkg::AW,
  parameter int unsigned   DW       = evt_irq_pkg::DW,
  parameter int unsigned   NL       = evt_irq_pkg::NUM_LINES,
  parameter logic [AW-1:0] EVT_OFS  = 'h004,
  parameter logic [AW-1:0] MASK_OFS = 'h008,
  parameter logic [AW-1:0] MGMT_OFS = 'h040,
  parameter logic [AW-1:0] TXC_OFS  = 'h0C4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [NL-1:0] evt_set_i,
  input logic [NL-1:0] irq_o,
  input logic [NL-1:0] evt_q,
  input logic [DW-1:0] mask_q
);

  // R4
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == MASK_OFS |=> mask_q == $past(reg_wdata_i));

  // R7
  mgmt_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == MGMT_OFS |=> evt_q[6]);

  // R8
  gra_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == TXC_OFS && reg_wdata_i[0] |=> evt_q[9]);

  for (genvar l = 0; l < NL; l++) begin : g_chk
    // R5
    irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[l] == (evt_q[l] && mask_q[line_bit(l)]));

    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_set_i[l] |=> evt_q[l]);

    // R3
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_we_i && reg_addr_i == EVT_OFS && reg_wdata_i[line_bit(l)] && !evt_set_i[l]
      |=> !evt_q[l]);
  end

endmodule

bind evt_irq_agg evt_irq_agg_chk #(
  .AW(AW), .DW(DW), .NL(NL),
  .EVT_OFS(EVT_OFS), .MASK_OFS(MASK_OFS), .MGMT_OFS(MGMT_OFS), .TXC_OFS(TXC_OFS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .evt_set_i   (evt_set_i),
  .irq_o       (irq_o),
  .evt_q       (evt_q),
  .mask_q      (mask_q)
);

// File: tb/test_evt_irq_agg.sv
`timescale 1ns/1ps
module test_evt_irq_agg;

  localparam int NL = 13;
  localparam logic [9:0] A_EVT = 10'h004, A_MASK = 10'h008, A_MGMT = 10'h040,
                         A_TXC = 10'h0C4, A_NONE = 10'h100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [9:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [12:0] evt_set_i = '0;
  logic [12:0] irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_evt = '0, m_mask = '0;

  always #4 clk_i = ~clk_i;

  evt_irq_agg i_evt_irq_agg (.*);

  function automatic int ref_bit(int l);
    int t[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return t[l];
  endfunction

  function automatic logic [31:0] impl_bits();
    logic [31:0] r = '0;
    for (int l = 0; l < NL; l++) r[ref_bit(l)] = 1'b1;
    return r;
  endfunction

  function automatic logic [12:0] exp_irq();
    logic [12:0] r;
    for (int l = 0; l < NL; l++) r[l] = m_evt[ref_bit(l)] & m_mask[ref_bit(l)];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic we, logic [9:0] a, logic [31:0] d, logic [12:0] s);
    logic [31:0] clr, set;
    @(negedge clk_i);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = d; evt_set_i = s;
    @(posedge clk_i);
    #1;
    reg_we_i = 1'b0; evt_set_i = '0;
    clr = (we && a == A_EVT) ? d : '0;
    set = '0;
    for (int l = 0; l < NL; l++) if (s[l]) set[ref_bit(l)] = 1'b1;
    if (we && a == A_MGMT) set[23] = 1'b1;
    if (we && a == A_TXC && d[0]) set[28] = 1'b1;
    m_evt = ((m_evt & ~clr) | set) & impl_bits();
    if (we && a == A_MASK) m_mask = d;
  endtask

  task automatic check_all(string tag);
    reg_addr_i = A_EVT;  #0.5;
    chk({tag, " evt"}, reg_rdata_o, m_evt);
    reg_addr_i = A_MASK; #0.5;
    chk({tag, " mask"}, reg_rdata_o, m_mask);
    chk({tag, " irq"}, {19'b0, irq_o}, {19'b0, exp_irq()});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    check_all("R1");

    // R2 / R6: each line alone, mask all ones
    cycle(1'b1, A_MASK, 32'hFFFF_FFFF, '0);
    for (int l = 0; l < NL; l++) begin
      cycle(1'b0, A_EVT, '0, 13'(1) << l);
      check_all("R2");
      chk("R6 line", {19'b0, irq_o}, 32'(13'(1) << l));
      cycle(1'b1, A_EVT, 32'(1) << ref_bit(l), '0);
      check_all("R3");
    end

    // R3 partial clear
    cycle(1'b0, A_EVT, '0, 13'h1FFF);
    cycle(1'b1, A_EVT, 32'h0A50_0000, '0);
    check_all("R3");

    // R4 mask replace, gating lines
    cycle(1'b1, A_MASK, 32'h5A5A_1234, '0);
    check_all("R4");
    cycle(1'b1, A_MASK, 32'h0000_0000, '0);
    check_all("R5");

    // R7 management write
    cycle(1'b1, A_MASK, 32'hFFFF_FFFF, '0);
    cycle(1'b1, A_EVT, 32'hFFFF_FFFF, '0);
    cycle(1'b1, A_MGMT, 32'h0, '0);
    check_all("R7");
    chk("R7 bit23", 32'(reg_rdata_o_evt()), 32'h0080_0000);

    // R8 stop-complete on bit0 only
    cycle(1'b1, A_EVT, 32'hFFFF_FFFF, '0);
    cycle(1'b1, A_TXC, 32'hFFFF_FFFE, '0);
    check_all("R8");
    chk("R8 bit0 clear", reg_rdata_o_evt(), 32'h0);
    cycle(1'b1, A_TXC, 32'h1, '0);
    check_all("R8");
    chk("R8 bit0 set", reg_rdata_o_evt(), 32'h1000_0000);

    // R9 same-cycle set and clear
    cycle(1'b1, A_EVT, 32'hFFFF_FFFF, 13'h0041);
    check_all("R9");
    chk("R9 survive", reg_rdata_o_evt(), 32'h0880_0000);

    // R10 unused offsets and bits
    cycle(1'b1, A_NONE, 32'hFFFF_FFFF, '0);
    check_all("R10");
    reg_addr_i = A_NONE; #0.5;
    chk("R10 read", reg_rdata_o, 32'h0);
    chk("R10 impl", reg_rdata_o_evt() & ~impl_bits(), 32'h0);

    // R5 random mix
    for (int i = 0; i < 400; i++) begin
      logic [9:0] a;
      case ($urandom % 5)
        0: a = A_EVT;
        1: a = A_MASK;
        2: a = A_MGMT;
        3: a = A_TXC;
        default: a = A_NONE;
      endcase
      cycle(($urandom % 10) < 7, a, $urandom,
            13'($urandom & $urandom & $urandom));
      check_all("R5");
    end

    finish_run();
  end

  function automatic logic [31:0] reg_rdata_o_evt();
    return m_evt_probe;
  endfunction

  logic [31:0] m_evt_probe;
  always_comb m_evt_probe = (reg_addr_i == A_EVT) ? reg_rdata_o : peek_evt;
  logic [31:0] peek_evt;
  always @(posedge clk_i or negedge clk_i) ;
  assign peek_evt = m_evt;

endmodule